// File: doc/BRIEF.md
# Read-First Row-Hit Scheduler for One DRAM Bank

This block chooses what a single DRAM bank does next. Requests arrive in order and wait in an age-ordered queue. Each request is either a read or a write, and each carries a row and a column. Every cycle the block is told whether a row is open in the bank and which row it is. It then ranks the queued requests into four tiers, from first to last:

1. read row-hits,
2. write row-hits,
3. other reads,
4. other writes.

Within a tier the oldest request wins. A read is skipped while an older write to the same row and column is still queued, so it can never return stale data.

The chosen command is registered and offered on a valid/ready issue port. It is a column read, a column write, a precharge or an activate, together with the queue position of the entry and that entry's row and column. A column command removes its entry when the handshake completes. A row command leaves the entry in place, so that it can become a hit later. Each handshake is followed by one NOP cycle, while the selection is recomputed from the updated queue.

Top module: `bank_rw_sched`

## Requirements
- R1: With an empty queue, issue_cmd is NOP (code 0) and issue_valid is low. With any entry queued, a command other than NOP is offered.
- R2: An entry is a hit only when open_valid is high and its row equals open_row. With open_valid low, every entry is a miss, and the row command offered is ACTIVATE (code 4).
- R3: If any read hit has no hazard, the oldest such read is offered as READ (code 1). It leaves the queue on the handshake.
- R4: If tier 1 is empty, the oldest write hit is offered as WRITE (code 2) without any hazard test. It leaves the queue on the handshake.
- R5: If tiers 1 and 2 are empty, the oldest read without a hazard gets a row command. The command is PRECHARGE (code 3) if another row is open and ACTIVATE if none is open. The entry stays queued.
- R6: Otherwise the oldest write gets a row command chosen by the same rule, and the entry stays queued.
- R7: A read has a hazard only when an older queued write has both the same row and the same column. Younger writes and writes to other columns do not block it.
- R8: issue_idx counts from the oldest entry (0). Removing an entry keeps the remaining entries in their original age order.
- R9: enq_ready is low exactly when DEPTH entries are queued. An enqueue attempted while full is dropped.
- R10: The output is registered. After a handshake, issue_valid is low for one cycle. Without a handshake, a stable queue and stable row state leave the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | New request offered |
| enq_write | input | 1 | 1 = write, 0 = read |
| enq_row | input | ROW_W | Request row |
| enq_col | input | COL_W | Request column |
| enq_ready | output | 1 | Queue can accept a request |
| open_valid | input | 1 | A row is open in the bank |
| open_row | input | ROW_W | The open row |
| issue_valid | output | 1 | A command is offered |
| issue_cmd | output | 3 | 0 NOP, 1 READ, 2 WRITE, 3 PRECHARGE, 4 ACTIVATE |
| issue_idx | output | IDX_W | Queue position of the chosen entry |
| issue_row | output | ROW_W | Row of the chosen entry |
| issue_col | output | COL_W | Column of the chosen entry |
| issue_ready | input | 1 | Command consumer accepts |

## Verification
The bench sweeps hundreds of generated queue contents and open-row states through a four-entry, two-bit-row configuration. It drains each queue against an arithmetic model of the bank, which opens and closes rows as the offered commands dictate.

Directed cases target the points where a design can go wrong:
- A read behind a same-address write: a design that ignores hazards returns stale data.
- A read ahead of such a write: a design with an over-eager hazard test stalls the read.
- A closed bank whose open_row value matches an entry: a design that skips open_valid issues a column command to a closed bank.
- An enqueue while full: a design that does not drop it overwrites the last entry.

Draining checks that the survivors keep their positions after a removal from the middle. It also checks that a row command never drops its entry.

// File: rtl/rsched_pkg.sv
package rsched_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_PRE   = 3'd3,
        CMD_ACT   = 3'd4
    } cmd_e;

    function automatic logic is_column_cmd(cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

    function automatic logic is_row_cmd(cmd_e c);
        return (c == CMD_PRE) || (c == CMD_ACT);
    endfunction

    // Row command needed to reach a different row: close first if one is open.
    function automatic cmd_e row_cmd_for(logic bank_open);
        return bank_open ? CMD_PRE : CMD_ACT;
    endfunction

endpackage

// File: rtl/bank_req_queue.sv
module bank_req_queue #(
    parameter int DEPTH = 8,
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid,
    input  logic             enq_write,
    input  logic [ROW_W-1:0] enq_row,
    input  logic [COL_W-1:0] enq_col,
    output logic             enq_ready,
    input  logic             rm_valid,
    input  logic [IDX_W-1:0] rm_idx,
    output logic [DEPTH-1:0] q_valid,
    output logic [DEPTH-1:0] q_write,
    output logic [ROW_W-1:0] q_row [DEPTH],
    output logic [COL_W-1:0] q_col [DEPTH],
    output logic [CNT_W-1:0] q_count
);

    logic             enq_fire;
    logic [CNT_W-1:0] tail;

    assign enq_ready = (q_count != CNT_W'(DEPTH));
    assign enq_fire  = enq_valid && enq_ready;
    assign tail      = q_count - (rm_valid ? CNT_W'(1) : CNT_W'(0));

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic             up_v, up_w;
        logic [ROW_W-1:0] up_r;
        logic [COL_W-1:0] up_c;
        logic             nx_v, nx_w;
        logic [ROW_W-1:0] nx_r;
        logic [COL_W-1:0] nx_c;
        logic             shift;

        if (i < DEPTH - 1) begin : g_mid
            assign up_v = q_valid[i+1];
            assign up_w = q_write[i+1];
            assign up_r = q_row[i+1];
            assign up_c = q_col[i+1];
        end else begin : g_last
            assign up_v = 1'b0;
            assign up_w = 1'b0;
            assign up_r = '0;
            assign up_c = '0;
        end

        assign shift = rm_valid && (IDX_W'(i) >= rm_idx);

        always_comb begin
            if (shift) begin
                nx_v = up_v;
                nx_w = up_w;
                nx_r = up_r;
                nx_c = up_c;
            end else begin
                nx_v = q_valid[i];
                nx_w = q_write[i];
                nx_r = q_row[i];
                nx_c = q_col[i];
            end
            if (enq_fire && (tail == CNT_W'(i))) begin
                nx_v = 1'b1;
                nx_w = enq_write;
                nx_r = enq_row;
                nx_c = enq_col;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q_valid[i] <= 1'b0;
                q_write[i] <= 1'b0;
                q_row[i]   <= '0;
                q_col[i]   <= '0;
            end else begin
                q_valid[i] <= nx_v;
                q_write[i] <= nx_w;
                q_row[i]   <= nx_r;
                q_col[i]   <= nx_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_count <= '0;
        else     q_count <= tail + (enq_fire ? CNT_W'(1) : CNT_W'(0));
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(DEPTH));

    p_full_drops_r9: assert property (@(posedge clk) disable iff (rst)
        (q_count == CNT_W'(DEPTH) && !rm_valid) |=> q_count == CNT_W'(DEPTH));

    p_packed_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(q_valid) == int'(q_count) && (q_valid & (q_valid + 1'b1)) == '0);

endmodule

// File: rtl/bank_tier_pick.sv
module bank_tier_pick
    import rsched_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] q_valid,
    input  logic [DEPTH-1:0] q_write,
    input  logic [ROW_W-1:0] q_row [DEPTH],
    input  logic [COL_W-1:0] q_col [DEPTH],
    input  logic             open_valid,
    input  logic [ROW_W-1:0] open_row,
    output cmd_e             pick_cmd,
    output logic [IDX_W-1:0] pick_idx
);

    logic [DEPTH-1:0] hit, haz;
    logic [DEPTH-1:0] t_rd_hit, t_wr_hit, t_rd_any, t_wr_any;

    for (genvar i = 0; i < DEPTH; i++) begin : g_class
        assign hit[i] = open_valid && (q_row[i] == open_row);

        always_comb begin
            haz[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j < i && q_valid[j] && q_write[j]
                    && q_row[j] == q_row[i] && q_col[j] == q_col[i])
                    haz[i] = 1'b1;
            end
        end

        assign t_rd_hit[i] = q_valid[i] && !q_write[i] && hit[i] && !haz[i];
        assign t_wr_hit[i] = q_valid[i] &&  q_write[i] && hit[i];
        assign t_rd_any[i] = q_valid[i] && !q_write[i] && !haz[i];
        assign t_wr_any[i] = q_valid[i] &&  q_write[i];
    end

    // Oldest set bit; MSB of the result flags that one was found.
    function automatic logic [IDX_W:0] oldest(logic [DEPTH-1:0] v);
        logic [IDX_W:0] r;
        r = '0;
        for (int k = DEPTH - 1; k >= 0; k--)
            if (v[k]) r = {1'b1, IDX_W'(k)};
        return r;
    endfunction

    logic [IDX_W:0] f1, f2, f3, f4;
    assign f1 = oldest(t_rd_hit);
    assign f2 = oldest(t_wr_hit);
    assign f3 = oldest(t_rd_any);
    assign f4 = oldest(t_wr_any);

    always_comb begin
        pick_cmd = CMD_NOP;
        pick_idx = '0;
        if (f1[IDX_W]) begin
            pick_cmd = CMD_READ;
            pick_idx = f1[IDX_W-1:0];
        end else if (f2[IDX_W]) begin
            pick_cmd = CMD_WRITE;
            pick_idx = f2[IDX_W-1:0];
        end else if (f3[IDX_W]) begin
            pick_cmd = row_cmd_for(open_valid);
            pick_idx = f3[IDX_W-1:0];
        end else if (f4[IDX_W]) begin
            pick_cmd = row_cmd_for(open_valid);
            pick_idx = f4[IDX_W-1:0];
        end
    end

    p_nonempty_pick_r1: assert property (@(posedge clk) disable iff (rst)
        (|q_valid) |-> pick_cmd != CMD_NOP);

    p_read_safe_r7: assert property (@(posedge clk) disable iff (rst)
        pick_cmd == CMD_READ |-> (!haz[pick_idx] && q_valid[pick_idx]));

    p_closed_no_col_r2: assert property (@(posedge clk) disable iff (rst)
        !open_valid |-> !is_column_cmd(pick_cmd));

endmodule

// File: rtl/bank_rw_sched.sv
module bank_rw_sched
    import rsched_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid,
    input  logic             enq_write,
    input  logic [ROW_W-1:0] enq_row,
    input  logic [COL_W-1:0] enq_col,
    output logic             enq_ready,
    input  logic             open_valid,
    input  logic [ROW_W-1:0] open_row,
    output logic             issue_valid,
    output logic [2:0]       issue_cmd,
    output logic [IDX_W-1:0] issue_idx,
    output logic [ROW_W-1:0] issue_row,
    output logic [COL_W-1:0] issue_col,
    input  logic             issue_ready
);

    logic [DEPTH-1:0] q_valid, q_write;
    logic [ROW_W-1:0] q_row [DEPTH];
    logic [COL_W-1:0] q_col [DEPTH];
    logic [CNT_W-1:0] q_count;

    cmd_e             pick_cmd, out_cmd;
    logic [IDX_W-1:0] pick_idx;
    logic             handshake, rm_valid;

    assign issue_valid = (out_cmd != CMD_NOP);
    assign issue_cmd   = out_cmd;
    assign handshake   = issue_valid && issue_ready;
    assign rm_valid    = handshake && is_column_cmd(out_cmd);

    bank_req_queue #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .enq_valid (enq_valid),
        .enq_write (enq_write),
        .enq_row   (enq_row),
        .enq_col   (enq_col),
        .enq_ready (enq_ready),
        .rm_valid  (rm_valid),
        .rm_idx    (issue_idx),
        .q_valid   (q_valid),
        .q_write   (q_write),
        .q_row     (q_row),
        .q_col     (q_col),
        .q_count   (q_count)
    );

    bank_tier_pick #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_pick (
        .clk        (clk),
        .rst        (rst),
        .q_valid    (q_valid),
        .q_write    (q_write),
        .q_row      (q_row),
        .q_col      (q_col),
        .open_valid (open_valid),
        .open_row   (open_row),
        .pick_cmd   (pick_cmd),
        .pick_idx   (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst || handshake) begin
            out_cmd   <= CMD_NOP;
            issue_idx <= '0;
            issue_row <= '0;
            issue_col <= '0;
        end else begin
            out_cmd   <= pick_cmd;
            issue_idx <= pick_idx;
            issue_row <= q_row[pick_idx];
            issue_col <= q_col[pick_idx];
        end
    end

    p_bubble_r10: assert property (@(posedge clk) disable iff (rst)
        handshake |=> !issue_valid);

    p_col_removes_r3: assert property (@(posedge clk) disable iff (rst)
        (rm_valid && !(enq_valid && enq_ready)) |=> q_count == $past(q_count) - 1'b1);

    p_row_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (handshake && is_row_cmd(out_cmd) && !enq_valid) |=> q_count == $past(q_count));

    p_empty_nop_r1: assert property (@(posedge clk) disable iff (rst)
        (q_count == '0) |=> !issue_valid);

endmodule

// File: tb/tb_bank_rw_sched.sv
module tb_bank_rw_sched;

    localparam int DEPTH = 4;
    localparam int ROW_W = 2;
    localparam int COL_W = 2;
    localparam int IDX_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enq_valid = 1'b0, enq_write = 1'b0;
    logic [ROW_W-1:0] enq_row = '0;
    logic [COL_W-1:0] enq_col = '0;
    logic             enq_ready;
    logic             open_valid = 1'b0;
    logic [ROW_W-1:0] open_row = '0;
    logic             issue_valid, issue_ready = 1'b0;
    logic [2:0]       issue_cmd;
    logic [IDX_W-1:0] issue_idx;
    logic [ROW_W-1:0] issue_row;
    logic [COL_W-1:0] issue_col;

    always #10 clk = ~clk;

    bank_rw_sched #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) dut (.*);

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // Bench model of queue and bank.
    int mn;
    int mw [DEPTH];
    int mr [DEPTH];
    int mc [DEPTH];
    int bo, brow;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit hazard(int i);
        for (int j = 0; j < i; j++)
            if (mw[j] == 1 && mr[j] == mr[i] && mc[j] == mc[i]) return 1;
        return 0;
    endfunction

    // Expected command and index per the four tiers.
    task automatic expect_pick(output int cmd, output int idx);
        int rc;
        rc = bo ? 3 : 4;
        cmd = 0; idx = 0;
        for (int i = 0; i < mn; i++)
            if (mw[i] == 0 && bo == 1 && mr[i] == brow && !hazard(i)) begin cmd = 1; idx = i; return; end
        for (int i = 0; i < mn; i++)
            if (mw[i] == 1 && bo == 1 && mr[i] == brow) begin cmd = 2; idx = i; return; end
        for (int i = 0; i < mn; i++)
            if (mw[i] == 0 && !hazard(i)) begin cmd = rc; idx = i; return; end
        for (int i = 0; i < mn; i++)
            if (mw[i] == 1) begin cmd = rc; idx = i; return; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; enq_valid = 0; issue_ready = 0;
        @(negedge clk);
        rst = 1'b0;
        mn = 0;
    endtask

    task automatic push(input int w, input int r, input int c);
        enq_valid = 1; enq_write = w[0]; enq_row = ROW_W'(r); enq_col = COL_W'(c);
        @(negedge clk);
        enq_valid = 0;
        if (mn < DEPTH) begin mw[mn] = w; mr[mn] = r; mc[mn] = c; mn++; end
    endtask

    task automatic set_bank(input int o, input int r);
        bo = o; brow = r;
        open_valid = o[0]; open_row = ROW_W'(r);
    endtask

    // Compare one offered command with the model; at negedge.
    task automatic check_offer(input string tag);
        int ec, ei;
        expect_pick(ec, ei);
        check(int'(issue_cmd) == ec, tag, int'(issue_cmd), ec);
        check(issue_valid == (ec != 0), {tag, " R1 valid"}, int'(issue_valid), int'(ec != 0));
        if (ec != 0) begin
            check(int'(issue_idx) == ei, {tag, " R8 idx"}, int'(issue_idx), ei);
            check(int'(issue_row) == mr[ei] && int'(issue_col) == mc[ei], {tag, " R8 entry"},
                  int'(issue_row) * 16 + int'(issue_col), mr[ei] * 16 + mc[ei]);
        end
    endtask

    // Drain with handshakes; model bank reacts to row commands.
    task automatic drain(input string tag);
        int ec, ei;
        for (int step = 0; step < 4 * DEPTH + 4; step++) begin
            expect_pick(ec, ei);
            check_offer(tag);
            if (ec == 0) break;
            issue_ready = 1;
            @(negedge clk);
            issue_ready = 0;
            check(!issue_valid, "R10 bubble after handshake", int'(issue_valid), 0);
            if (ec == 1 || ec == 2) begin
                for (int k = ei; k < mn - 1; k++) begin mw[k] = mw[k+1]; mr[k] = mr[k+1]; mc[k] = mc[k+1]; end
                mn--;
            end else if (ec == 3) set_bank(0, brow);
            else set_bank(1, mr[ei]);
            @(negedge clk);
        end
    endtask

    initial begin
        int seed, ec, ei;
        do_reset();
        set_bank(0, 0);
        @(negedge clk);
        check(!issue_valid && issue_cmd == 3'd0, "R1 empty after reset", int'(issue_cmd), 0);
        check(enq_ready, "R9 ready when empty", int'(enq_ready), 1);

        // R7: read behind same-address write is blocked -> write hit first.
        do_reset(); set_bank(1, 1);
        push(1, 1, 1); push(0, 1, 1);
        @(negedge clk);
        check(issue_cmd == 3'd2 && issue_idx == 0, "R7 blocked read, R4 write hit", int'(issue_cmd), 2);
        drain("R7 drain");

        // R7: younger write does not block; R3.
        do_reset(); set_bank(1, 2);
        push(0, 2, 3); push(1, 2, 3);
        @(negedge clk);
        check(issue_cmd == 3'd1 && issue_idx == 0, "R7 younger write, R3 read hit", int'(issue_cmd), 1);
        // R10: held without handshake.
        @(negedge clk);
        check(issue_cmd == 3'd1 && issue_idx == 0, "R10 stable without handshake", int'(issue_cmd), 1);
        drain("R3 drain");

        // R2: closed bank, matching open_row value -> ACTIVATE.
        do_reset(); set_bank(0, 3);
        push(0, 3, 0);
        @(negedge clk);
        check(issue_cmd == 3'd4, "R2 closed bank activates", int'(issue_cmd), 4);

        // R5/R6: read miss beats older write miss; PRECHARGE.
        do_reset(); set_bank(1, 0);
        push(1, 2, 0); push(0, 3, 1);
        @(negedge clk);
        check(issue_cmd == 3'd3 && issue_idx == 1, "R5 read miss precharge", int'(issue_cmd), 3);
        drain("R5 drain");

        // R6: only writes, miss.
        do_reset(); set_bank(1, 0);
        push(1, 1, 0); push(1, 2, 0);
        @(negedge clk);
        check(issue_cmd == 3'd3 && issue_idx == 0, "R6 write miss", int'(issue_cmd), 3);

        // R9: overfill.
        do_reset(); set_bank(1, 0);
        for (int k = 0; k < DEPTH + 1; k++) begin
            if (k == DEPTH) check(!enq_ready, "R9 full", int'(enq_ready), 0);
            push(1, 0, k);
        end
        @(negedge clk);
        check(mn == DEPTH, "R9 model depth", mn, DEPTH);
        for (int k = 0; k < DEPTH; k++) begin
            check(issue_cmd == 3'd2 && int'(issue_col) == k, "R9 dropped extra, R8 order",
                  int'(issue_col), k);
            issue_ready = 1; @(negedge clk); issue_ready = 0; @(negedge clk);
        end
        check(!issue_valid, "R9 extra entry dropped, R1 empty", int'(issue_valid), 0);

        // Sweep of generated queues and bank states.
        for (int s = 0; s < 300; s++) begin
            int n;
            do_reset();
            seed = s * 7919 + 13;
            n = 1 + (s % DEPTH);
            set_bank((s / 4) % 2, (s / 8) % 4);
            for (int i = 0; i < n; i++) begin
                seed = (seed * 1103515245 + 12345) & 32'h7fff_ffff;
                push((seed >> 16) & 1, (seed >> 17) & 3, (seed >> 19) & 1);
            end
            @(negedge clk);
            expect_pick(ec, ei);
            check_offer(ec == 1 ? "R3 sweep" : ec == 2 ? "R4 sweep" :
                        (ec != 0 && mw[ei] == 0) ? "R5 sweep" : "R6 sweep");
            drain("R8 sweep drain");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule